// File: doc/BRIEF.md
# Tiled Mirror Address Generator

This block produces the address stream that mirrors an 8-bit single-channel frame. The frame is moved in tiles of 256 by 128 pixels, 32 pixels (one group) per beat. The caller samples the flip mode, the frame size and two base offsets on a start pulse. The block then emits one beat per group. Each beat carries a source byte address, a destination byte address and a lane-reverse flag. The pixel mover reads 32 bytes at the source address, reverses their lane order if the flag is set, and writes them at the destination address.

The mirror is split over two levels. The tile grid is walked with its column and/or row order reversed, and each tile is mirrored internally by reversing rows, reversing the order of the groups, and reversing the lanes inside each group. A buffer-select bit tells a two-buffer tile store which half the current tile belongs to, so that one tile can be moved while the next is processed.

The output is a valid/ready stream. `out_valid` stays high for the whole frame. A beat is taken on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the beat on the outputs is held unchanged. The consumer may apply back-pressure at any time, for any number of cycles.

Top module: `tflip_agen`

## Requirements
- R1: A start is rejected when `frame_w` is zero or not a multiple of 256, or when `frame_h` is zero or not a multiple of 128. A rejected start sets `cfg_err` from the next cycle, and no beat and no `done` follow. The next accepted start clears `cfg_err`.
- R2: `mode` bit 0 mirrors columns and bit 1 mirrors rows (00 plain copy, 01 columns, 10 rows, 11 both). Lane k of each beat's destination group receives the source pixel given by dst(x,y)=src(x',y'). Here x'=W-1-x when columns mirror and x otherwise, and y'=H-1-y when rows mirror and y otherwise.
- R3: A frame yields exactly W*H/32 beats. Destination tiles are visited left to right, then top to bottom. Within a tile, the beats step through the eight groups of a row before moving to the next row, and the rows go in order of the counter.
- R4: Source tile (i,j) feeds destination tile (a,b). Here i=w-1-a when columns mirror and i=a otherwise, and j=h-1-b when rows mirror and j=b otherwise, where w and h are the tile counts.
- R5: Both addresses have the form base + row*W + column. The destination column of a beat is a multiple of 32. In column mode, local group g is written at tile column 224-32g.
- R6: `lane_rev` equals `mode` bit 0 on every beat of the frame.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `src_addr` and `dst_addr` stay unchanged on the next cycle.
- R8: `done` is high for exactly one cycle, the cycle after the last beat is taken, and `out_valid` is low in that cycle.
- R9: `buf_sel` is 0 during the first tile of a frame and flips at every tile boundary.
- R10: A start during a running frame is ignored, and `mode`, `frame_w`, `frame_h` and the bases are used only as sampled at the accepted start.
- R11: During and after reset, `out_valid`, `done`, `cfg_err` and `buf_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| mode | input | 2 | Flip mode: bit 0 columns, bit 1 rows |
| frame_w | input | 16 | Frame width in pixels |
| frame_h | input | 16 | Frame height in pixels |
| src_base | input | 32 | Source frame byte base |
| dst_base | input | 32 | Destination frame byte base |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer takes the beat |
| src_addr | output | 32 | Byte address of the 32-pixel source group |
| dst_addr | output | 32 | Byte address of the 32-pixel destination group |
| lane_rev | output | 1 | Reverse the 32 lanes before writing |
| buf_sel | output | 1 | Tile buffer half of the current tile |
| done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | Last start was rejected for its dimensions |

## Verification
Two situations are hard to reach from the ports. The first is a stall that falls exactly on a tile boundary or on the final beat. The second is a start pulse, with different mode and width on the inputs, that arrives in the middle of a frame. The bench drives `out_ready` from a pseudo-random sequence over multi-tile frames, so stalls land on every kind of beat. On one stalled frame it fires a start with altered inputs at beat 100 and keeps checking the stream against the original settings. Every beat is checked lane by lane against the per-pixel mirror formula, on 512x256 frames in all four modes.

// File: rtl/tflip_pkg.sv
package tflip_pkg;

  typedef enum logic [1:0] {
    FLIP_NONE = 2'b00,
    FLIP_COLS = 2'b01,
    FLIP_ROWS = 2'b10,
    FLIP_BOTH = 2'b11
  } flip_mode_e;

  function automatic logic cols_mirrored(flip_mode_e m);
    return m[0];
  endfunction

  function automatic logic rows_mirrored(flip_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/tflip_cfg_check.sv
module tflip_cfg_check #(
  parameter int DIM_W = 16,
  parameter int TW_LG = 8,
  parameter int TH_LG = 7
) (
  input  logic [DIM_W-1:0] frame_w,
  input  logic [DIM_W-1:0] frame_h,
  output logic             dims_ok,
  output logic [DIM_W-1:0] tiles_x_m1,
  output logic [DIM_W-1:0] tiles_y_m1
);

  logic [DIM_W-1:0] tiles_x;
  logic [DIM_W-1:0] tiles_y;

  always_comb begin
    tiles_x    = frame_w >> TW_LG;
    tiles_y    = frame_h >> TH_LG;
    tiles_x_m1 = tiles_x - 1'b1;
    tiles_y_m1 = tiles_y - 1'b1;
    dims_ok    = (frame_w[TW_LG-1:0] == '0) && (frame_h[TH_LG-1:0] == '0) &&
                 (tiles_x != '0) && (tiles_y != '0);
  end

endmodule

// File: rtl/tflip_scan.sv
module tflip_scan #(
  parameter int DIM_W = 16,
  parameter int GRP_W = 3,
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [DIM_W-1:0] tiles_x_m1,
  input  logic [DIM_W-1:0] tiles_y_m1,
  output logic             active,
  output logic [GRP_W-1:0] grp,
  output logic [ROW_W-1:0] row,
  output logic [DIM_W-1:0] tcol,
  output logic [DIM_W-1:0] trow,
  output logic             buf_sel,
  output logic             done
);

  localparam logic [GRP_W-1:0] GRP_LAST = {GRP_W{1'b1}};
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};

  logic grp_end, tile_end, col_end, frame_end;

  always_comb begin
    grp_end   = (grp == GRP_LAST);
    tile_end  = grp_end && (row == ROW_LAST);
    col_end   = tile_end && (tcol == tiles_x_m1);
    frame_end = col_end && (trow == tiles_y_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      grp     <= '0;
      row     <= '0;
      tcol    <= '0;
      trow    <= '0;
      buf_sel <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        active  <= 1'b1;
        grp     <= '0;
        row     <= '0;
        tcol    <= '0;
        trow    <= '0;
        buf_sel <= 1'b0;
      end else if (step && active) begin
        grp <= grp + 1'b1;
        if (grp_end) begin
          row <= row + 1'b1;
        end
        if (tile_end) begin
          buf_sel <= ~buf_sel;
          tcol    <= col_end ? '0 : tcol + 1'b1;
        end
        if (col_end) begin
          trow <= trow + 1'b1;
        end
        if (frame_end) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  AST_BUF_FLIPS_AT_TILE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active && tile_end && !load) |=> (buf_sel != $past(buf_sel))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

endmodule

// File: rtl/tflip_addr_map.sv
module tflip_addr_map
  import tflip_pkg::*;
#(
  parameter int DIM_W   = 16,
  parameter int ADDR_W  = 32,
  parameter int TW_LG   = 8,
  parameter int TH_LG   = 7,
  parameter int LANE_LG = 5,
  parameter int GRP_W   = TW_LG - LANE_LG,
  parameter int ROW_W   = TH_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  flip_mode_e        mode,
  input  logic [DIM_W-1:0]  frame_w,
  input  logic [DIM_W-1:0]  tiles_x_m1,
  input  logic [DIM_W-1:0]  tiles_y_m1,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [GRP_W-1:0]  grp,
  input  logic [ROW_W-1:0]  row,
  input  logic [DIM_W-1:0]  tcol,
  input  logic [DIM_W-1:0]  trow,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              lane_rev
);

  localparam logic [ADDR_W-1:0] LANE_MASK = ADDR_W'((1 << LANE_LG) - 1);

  logic              hflip, vflip;
  logic [DIM_W-1:0]  src_tcol, src_trow;
  logic [GRP_W-1:0]  dst_grp;
  logic [ROW_W-1:0]  dst_row;
  logic [ADDR_W-1:0] width_a;
  logic [ADDR_W-1:0] src_y, src_x, dst_y, dst_x;

  always_comb begin
    hflip    = cols_mirrored(mode);
    vflip    = rows_mirrored(mode);
    // tile grid mirror: source tile chosen from the destination position
    src_tcol = hflip ? (tiles_x_m1 - tcol) : tcol;
    src_trow = vflip ? (tiles_y_m1 - trow) : trow;
    // in-tile mirror: the all-ones maximum makes the complement the reversed index
    dst_grp  = hflip ? ~grp : grp;
    dst_row  = vflip ? ~row : row;
    width_a  = ADDR_W'(frame_w);
    src_y    = (ADDR_W'(src_trow) << TH_LG) + ADDR_W'(row);
    src_x    = (ADDR_W'(src_tcol) << TW_LG) + (ADDR_W'(grp) << LANE_LG);
    dst_y    = (ADDR_W'(trow) << TH_LG) + ADDR_W'(dst_row);
    dst_x    = (ADDR_W'(tcol) << TW_LG) + (ADDR_W'(dst_grp) << LANE_LG);
    src_addr = src_base + src_y * width_a + src_x;
    dst_addr = dst_base + dst_y * width_a + dst_x;
    lane_rev = hflip;
  end

  AST_DST_GROUP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (((dst_addr - dst_base) & LANE_MASK) == '0)); // R5

  AST_SRC_GROUP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (((src_addr - src_base) & LANE_MASK) == '0)); // R5

endmodule

// File: rtl/tflip_agen.sv
module tflip_agen
  import tflip_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int ADDR_W = 32,
  parameter int TILE_W = 256,
  parameter int TILE_H = 128,
  parameter int LANES  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [DIM_W-1:0]  frame_w,
  input  logic [DIM_W-1:0]  frame_h,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              lane_rev,
  output logic              buf_sel,
  output logic              done,
  output logic              cfg_err
);

  localparam int TW_LG   = $clog2(TILE_W);
  localparam int TH_LG   = $clog2(TILE_H);
  localparam int LANE_LG = $clog2(LANES);
  localparam int GRP_W   = TW_LG - LANE_LG;
  localparam int ROW_W   = TH_LG;

  logic              dims_ok;
  logic [DIM_W-1:0]  tx_m1_in, ty_m1_in;
  logic [DIM_W-1:0]  tx_m1_q, ty_m1_q, fw_q;
  logic [ADDR_W-1:0] sbase_q, dbase_q;
  flip_mode_e        mode_q;
  logic              active, accept, load, fire;
  logic [GRP_W-1:0]  grp;
  logic [ROW_W-1:0]  row;
  logic [DIM_W-1:0]  tcol, trow;

  tflip_cfg_check #(
    .DIM_W(DIM_W), .TW_LG(TW_LG), .TH_LG(TH_LG)
  ) u_cfg (
    .frame_w    (frame_w),
    .frame_h    (frame_h),
    .dims_ok    (dims_ok),
    .tiles_x_m1 (tx_m1_in),
    .tiles_y_m1 (ty_m1_in)
  );

  always_comb begin
    accept    = start && !active;
    load      = accept && dims_ok;
    out_valid = active;
    fire      = active && out_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
      mode_q  <= FLIP_NONE;
      fw_q    <= '0;
      tx_m1_q <= '0;
      ty_m1_q <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
    end else if (accept) begin
      cfg_err <= !dims_ok;
      if (dims_ok) begin
        mode_q  <= flip_mode_e'(mode);
        fw_q    <= frame_w;
        tx_m1_q <= tx_m1_in;
        ty_m1_q <= ty_m1_in;
        sbase_q <= src_base;
        dbase_q <= dst_base;
      end
    end
  end

  tflip_scan #(
    .DIM_W(DIM_W), .GRP_W(GRP_W), .ROW_W(ROW_W)
  ) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (fire),
    .tiles_x_m1 (tx_m1_q),
    .tiles_y_m1 (ty_m1_q),
    .active     (active),
    .grp        (grp),
    .row        (row),
    .tcol       (tcol),
    .trow       (trow),
    .buf_sel    (buf_sel),
    .done       (done)
  );

  tflip_addr_map #(
    .DIM_W(DIM_W), .ADDR_W(ADDR_W), .TW_LG(TW_LG), .TH_LG(TH_LG),
    .LANE_LG(LANE_LG), .GRP_W(GRP_W), .ROW_W(ROW_W)
  ) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (out_valid),
    .mode       (mode_q),
    .frame_w    (fw_q),
    .tiles_x_m1 (tx_m1_q),
    .tiles_y_m1 (ty_m1_q),
    .src_base   (sbase_q),
    .dst_base   (dbase_q),
    .grp        (grp),
    .row        (row),
    .tcol       (tcol),
    .trow       (trow),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .lane_rev   (lane_rev)
  );

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(src_addr) && $stable(dst_addr))); // R7

  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R8

  AST_ERR_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !out_valid); // R1

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && out_valid) |=> ($stable(mode_q) && $stable(fw_q) && $stable(dbase_q))); // R10

endmodule

// File: tb/tflip_agen_tb.sv
module tflip_agen_tb;

  localparam int TW = 256;
  localparam int TH = 128;
  localparam int LN = 32;
  localparam int GPT = TW / LN;
  localparam logic [31:0] SB = 32'h0010_0000;
  localparam logic [31:0] DB = 32'h0080_0040;
  localparam int NV = 10;
  // fields: width[35:20] height[19:4] mode[3:2] stall+poke[1] expect_error[0]
  localparam logic [35:0] VEC [NV] = '{
    {16'd512, 16'd256, 2'd0, 1'b0, 1'b0},
    {16'd512, 16'd256, 2'd1, 1'b0, 1'b0},
    {16'd512, 16'd256, 2'd2, 1'b0, 1'b0},
    {16'd512, 16'd256, 2'd3, 1'b0, 1'b0},
    {16'd768, 16'd256, 2'd3, 1'b1, 1'b0},
    {16'd256, 16'd128, 2'd1, 1'b1, 1'b0},
    {16'd300, 16'd128, 2'd1, 1'b0, 1'b1},
    {16'd512, 16'd100, 2'd2, 1'b0, 1'b1},
    {16'd0,   16'd128, 2'd3, 1'b0, 1'b1},
    {16'd256, 16'd256, 2'd2, 1'b1, 1'b0}
  };

  logic        clk, rst_n, start, out_ready;
  logic [1:0]  mode;
  logic [15:0] frame_w, frame_h;
  logic [31:0] src_base, dst_base;
  logic        out_valid, lane_rev, buf_sel, done, cfg_err;
  logic [31:0] src_addr, dst_addr;
  int checks = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  tflip_agen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .frame_w(frame_w), .frame_h(frame_h), .src_base(src_base), .dst_base(dst_base),
    .out_valid(out_valid), .out_ready(out_ready), .src_addr(src_addr), .dst_addr(dst_addr),
    .lane_rev(lane_rev), .buf_sel(buf_sel), .done(done), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_beat(input int n, input int w, input int h, input logic [1:0] m);
    int g, r, t, tw, th, a, b, soff, doff, dx, dy, sx, sy, sl, bad;
    bit hf, vf;
    logic [31:0] exp_dst;
    hf = m[0]; vf = m[1];
    tw = w / TW; th = h / TH;
    g = n % GPT; r = (n / GPT) % TH; t = n / (GPT * TH);
    a = t % tw; b = t / tw;
    exp_dst = DB + 32'((b * TH + (vf ? TH - 1 - r : r)) * w + a * TW + (hf ? (GPT - 1 - g) * LN : g * LN));
    chk(dst_addr == exp_dst, "R3 R5", "destination address", dst_addr, exp_dst);
    chk(lane_rev == hf, "R6", "lane reverse", lane_rev, hf);
    chk(buf_sel == t[0], "R9", "buffer select", buf_sel, t[0]);
    soff = int'(src_addr - SB);
    chk(((soff % w) / TW == (hf ? tw - 1 - a : a)) && ((soff / w) / TH == (vf ? th - 1 - b : b)),
        "R4", "source tile index", (soff % w) / TW, hf ? tw - 1 - a : a);
    bad = 0;
    for (int k = 0; k < LN; k++) begin
      doff = int'(dst_addr - DB) + k;
      dx = doff % w; dy = doff / w;
      sx = hf ? w - 1 - dx : dx;
      sy = vf ? h - 1 - dy : dy;
      sl = hf ? LN - 1 - k : k;
      if (soff + sl != sy * w + sx) bad++;
    end
    chk(bad == 0, "R2", "lanes off the mirror formula", bad, 0);
  endtask

  task automatic run_frame(input int w, input int h, input logic [1:0] m,
                           input bit stall, input bit err);
    int n, nexp;
    bit pv, pr, poked, after_poke;
    logic [31:0] psrc, pdst;
    @(negedge clk);
    frame_w = w[15:0]; frame_h = h[15:0]; mode = m;
    src_base = SB; dst_base = DB; start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (err) begin
      chk(cfg_err == 1'b1, "R1", "error flag on bad size", cfg_err, 1);
      chk(out_valid == 1'b0, "R1", "no beats on bad size", out_valid, 0);
      @(negedge clk);
      chk(done == 1'b0 && out_valid == 1'b0, "R1", "stays idle after rejection", done, 0);
      return;
    end
    chk(cfg_err == 1'b0, "R1", "error flag on good size", cfg_err, 0);
    nexp = w * h / LN;
    n = 0; pv = 0; pr = 0; poked = 0; after_poke = 0; psrc = '0; pdst = '0;
    while (n < nexp) begin
      if (pv && !pr)
        chk(out_valid && src_addr == psrc && dst_addr == pdst, "R7", "beat held while stalled",
            dst_addr, pdst);
      if (after_poke) begin
        chk(out_valid && lane_rev == m[0], "R10", "start mid-frame ignored", lane_rev, m[0]);
        after_poke = 0;
      end
      pv = out_valid; psrc = src_addr; pdst = dst_addr;
      pr = stall ? (lfsr[1:0] != 2'b00) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = pr;
      start = 1'b0;
      if (stall && !poked && n == 100) begin
        start = 1'b1; mode = ~m; frame_w = 16'd256; frame_h = 16'd128; dst_base = 32'h0;
        poked = 1; after_poke = 1;
      end
      if (out_valid && pr) begin
        check_beat(n, w, h, m);
        n++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0; start = 1'b0;
    chk(done == 1'b1, "R8", "done after last beat", done, 1);
    chk(out_valid == 1'b0, "R3 R8", "no beat past the frame", out_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual run still going, expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0; mode = 2'd0;
    frame_w = '0; frame_h = '0; src_base = '0; dst_base = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && done == 0 && cfg_err == 0 && buf_sel == 0,
        "R11", "outputs in reset", {out_valid, done, cfg_err, buf_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && done == 0 && cfg_err == 0 && buf_sel == 0,
        "R11", "outputs after reset", {out_valid, done, cfg_err, buf_sel}, 0);
    for (int v = 0; v < NV; v++) begin
      run_frame(int'(VEC[v][35:20]), int'(VEC[v][19:4]), VEC[v][3:2], VEC[v][1], VEC[v][0]);
    end
    // error right after error, then a good frame clears the flag
    run_frame(384, 128, 2'd0, 1'b0, 1'b1);
    run_frame(256, 128, 2'd0, 1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule